// File: doc/BRIEF.md
# Queued ADC Command Sequencer

This block feeds an analog-to-digital converter from two command queues. Software (or a DMA engine) writes 32-bit command words into either queue. The sequencer takes one command at a time. It presents the command's channel number and sample-time code to the converter with a one-cycle start strobe, waits for the converter's done pulse, and then stores the 12-bit result as a 16-bit word in one of two result FIFOs. Each command chooses its own result FIFO.

Queue 0 is a single-scan queue. It runs only while its enable bit is set. That bit is set by a start pulse and cleared when a command marked end-of-queue has finished. Finishing that command also raises a sticky completion flag, which is cleared by writing 1. Queue 1 is a continuous-scan queue. While it is enabled, every command it issues is written back to its own tail, so the command list repeats without software help. Each queue raises a refill request when it is empty or close to empty.

The converter is outside the block and is treated as a responder that pulses done some cycles after each start.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: After reset both command queues and both result FIFOs are empty, `refillReq` is 2'b11, `cmdFull` is 2'b00, `resValid` is 2'b00, and `adcStart`, `ssBusy` and `scanDone` are low.
- R2: Command word layout:
  - bits [7:0] are the channel, driven on `adcChan` while `adcStart` is high;
  - bits [28:27] are the sample-time code, driven unchanged on `adcSample`;
  - bit 31 is end-of-queue;
  - bits [30:29] are the result selector;
  - bits [26:8] are reserved and have no effect.
- R3: Commands from one queue are issued in exactly the order they were written.
- R4: Queue 0 issues commands only while `ssBusy` is set. A one-cycle `ssStart` pulse sets `ssBusy`.
- R5: When a queue 0 command with bit 31 set has its result stored, `ssBusy` clears and `scanDone` sets on the same edge. If `ssStart` arrives on that edge, `ssBusy` stays set.
- R6: `doneClr` clears `scanDone`. If a completion falls on the same edge, the flag stays set.
- R7: While `contEnable` is high, each command issued from queue 1 is appended again to queue 1's tail. A write to queue 1 while `contEnable` is high is dropped.
- R8: Only one command is in flight at a time. When both queues are eligible at a command boundary, queue 0 goes first.
- R9: Result routing uses bit 29: 0 sends the result to result FIFO 0 and 1 sends it to result FIFO 1. Bit 30 is ignored. Each result FIFO returns its results in the order they were stored.
- R10: A stored result word is the 12-bit converter value, right-justified, with bits [15:12] zero.
- R11: While the selected result FIFO is full, the pending result is held and no new `adcStart` is issued until the result has been stored.
- R12: `cmdFull[i]` is high when command queue i holds CMD_DEPTH words. `refillReq[i]` is high when it holds LOW_MARK words or fewer. A write to a full queue is dropped unless the same edge also removes a word from that queue.
- R13: With no eligible command, `adcStart` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdPush | input | 2 | Write strobe, one per command queue |
| cmdWord | input | 32 | Command word to write |
| contEnable | input | 1 | Run enable for the continuous queue |
| ssStart | input | 1 | Pulse that sets the single-scan enable |
| doneClr | input | 1 | Write-1 clear of the completion flag |
| cmdFull | output | 2 | Command queue full, one per queue |
| refillReq | output | 2 | Command queue low, one per queue |
| ssBusy | output | 1 | Single-scan enable state |
| scanDone | output | 1 | Sticky single-scan completion flag |
| adcStart | output | 1 | One-cycle conversion start |
| adcChan | output | 8 | Channel of the current command |
| adcSample | output | 2 | Sample-time code of the current command |
| adcDone | input | 1 | Conversion done pulse |
| adcData | input | 12 | Conversion value, valid with adcDone |
| resPop | input | 2 | Read strobe, one per result FIFO |
| resValid | output | 2 | Result FIFO not empty |
| resData0 | output | 16 | Head of result FIFO 0 |
| resData1 | output | 16 | Head of result FIFO 1 |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is completion of an end-of-queue command and a write-1 clear of the completion flag. The bench holds `doneClr` high through an entire single scan, so the clear meets the completion. It expects the flag to be set for exactly the cycle after completion and to be clear after that.

The second pair is recirculation on the continuous queue and a pop from that same queue. The bench runs the continuous queue while it is full, so the pop and the write-back fall on the same edge. It expects `cmdFull[1]` to stay high throughout. Meanwhile, queue 0 is started so that priority is taken at a command boundary.

A behavioural model built from queues is compared with every output on every cycle, including a long randomized phase with a random converter latency.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int CMD_W   = 32;
  localparam int ADC_W   = 12;
  localparam int RES_W   = 16;
  localparam int CHAN_W  = 8;
  localparam int EOQ_BIT = 31;
  localparam int RQ_BIT  = 29;
  localparam int SMP_HI  = 28;
  localparam int SMP_LO  = 27;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_WRITE
  } seqState_t;

  typedef struct packed {
    logic [1:0] cmdPop;
    logic       recirc;
    logic       loadCmd;
    logic       srcQ;
    logic       capture;
    logic       resPush;
    logic       eoqDone;
  } ctrlStrobe_t;
endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic                       pop,
  input  logic [WIDTH-1:0]           wrData,
  output logic [WIDTH-1:0]           rdData,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rdPtr;
  logic [AW-1:0]    wrPtr;
  logic [CW-1:0]    cnt;
  logic             doPop;
  logic             doPush;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign count  = cnt;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      cnt <= cnt + 1'b1;
      else if (doPop && !doPush) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int RES_DEPTH = 4,
  parameter int LOW_MARK  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdPush,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              contEnable,
  input  ctrlStrobe_t       strb,
  input  logic [ADC_W-1:0]  adcData,
  input  logic [1:0]        resPop,
  output logic [1:0]        cmdFull,
  output logic [1:0]        cmdEmpty,
  output logic [1:0]        refillReq,
  output logic [CMD_W-1:0]  curCmd,
  output logic [1:0]        resFull,
  output logic [1:0]        resValid,
  output logic [RES_W-1:0]  resHead0,
  output logic [RES_W-1:0]  resHead1
);
  localparam int CCW = $clog2(CMD_DEPTH + 1);
  localparam int RCW = $clog2(RES_DEPTH + 1);

  logic [CMD_W-1:0] cmdHead [2];
  logic [RES_W-1:0] resHead [2];
  logic [RES_W-1:0] resWord;

  for (genvar q = 0; q < 2; q++) begin : g_cmdq
    logic             pushQ;
    logic [CMD_W-1:0] dataQ;
    logic [CCW-1:0]   cntQ;
    logic             fullQ;
    logic             emptyQ;

    if (q == 1) begin : g_cont
      assign pushQ = strb.recirc | (cmdPush[1] & ~contEnable);
      assign dataQ = strb.recirc ? cmdHead[1] : cmdWord;
    end else begin : g_single
      assign pushQ = cmdPush[0];
      assign dataQ = cmdWord;
    end

    seq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_fifo (
      .clk(clk), .rstN(rstN), .push(pushQ), .pop(strb.cmdPop[q]),
      .wrData(dataQ), .rdData(cmdHead[q]), .count(cntQ),
      .full(fullQ), .empty(emptyQ)
    );

    assign cmdFull[q]   = fullQ;
    assign cmdEmpty[q]  = emptyQ;
    assign refillReq[q] = (cntQ <= CCW'(LOW_MARK));
  end

  for (genvar r = 0; r < 2; r++) begin : g_resq
    logic           pushR;
    logic [RCW-1:0] cntR;
    logic           fullR;
    logic           emptyR;

    assign pushR = strb.resPush && (curCmd[RQ_BIT] == 1'(r));

    seq_fifo #(.WIDTH(RES_W), .DEPTH(RES_DEPTH)) u_fifo (
      .clk(clk), .rstN(rstN), .push(pushR), .pop(resPop[r]),
      .wrData(resWord), .rdData(resHead[r]), .count(cntR),
      .full(fullR), .empty(emptyR)
    );

    assign resFull[r]  = fullR;
    assign resValid[r] = !emptyR;
  end

  assign resHead0 = resHead[0];
  assign resHead1 = resHead[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCmd  <= '0;
      resWord <= '0;
    end else begin
      if (strb.loadCmd) curCmd  <= cmdHead[strb.srcQ];
      if (strb.capture) resWord <= {{(RES_W - ADC_W){1'b0}}, adcData};
    end
  end
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ssStart,
  input  logic        contEnable,
  input  logic        doneClr,
  input  logic        adcDone,
  input  logic [1:0]  cmdEmpty,
  input  logic [1:0]  resFull,
  input  logic        curEoq,
  input  logic        curRq,
  output ctrlStrobe_t strb,
  output logic        adcStart,
  output logic        ssBusy,
  output logic        scanDone
);
  seqState_t state;
  seqState_t nextState;
  logic      srcReg;
  logic      ssEn;
  logic      doneFlag;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (ssEn && !cmdEmpty[0]) begin
          strb.loadCmd   = 1'b1;
          strb.srcQ      = 1'b0;
          strb.cmdPop[0] = 1'b1;
          nextState      = ST_ISSUE;
        end else if (contEnable && !cmdEmpty[1]) begin
          strb.loadCmd   = 1'b1;
          strb.srcQ      = 1'b1;
          strb.cmdPop[1] = 1'b1;
          strb.recirc    = 1'b1;
          nextState      = ST_ISSUE;
        end
      end
      ST_ISSUE: nextState = ST_WAIT;
      ST_WAIT: begin
        if (adcDone) begin
          strb.capture = 1'b1;
          nextState    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (!resFull[curRq]) begin
          strb.resPush = 1'b1;
          strb.eoqDone = (srcReg == 1'b0) && curEoq;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      srcReg   <= 1'b0;
      ssEn     <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.loadCmd) srcReg <= strb.srcQ;
      if (strb.eoqDone) ssEn <= 1'b0;
      if (ssStart)      ssEn <= 1'b1;
      if (doneClr)      doneFlag <= 1'b0;
      if (strb.eoqDone) doneFlag <= 1'b1;
    end
  end

  assign adcStart = (state == ST_ISSUE);
  assign ssBusy   = ssEn;
  assign scanDone = doneFlag;
endmodule

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer
  import seq_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int RES_DEPTH = 4,
  parameter int LOW_MARK  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdPush,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              contEnable,
  input  logic              ssStart,
  input  logic              doneClr,
  output logic [1:0]        cmdFull,
  output logic [1:0]        refillReq,
  output logic              ssBusy,
  output logic              scanDone,
  output logic              adcStart,
  output logic [CHAN_W-1:0] adcChan,
  output logic [1:0]        adcSample,
  input  logic              adcDone,
  input  logic [ADC_W-1:0]  adcData,
  input  logic [1:0]        resPop,
  output logic [1:0]        resValid,
  output logic [RES_W-1:0]  resData0,
  output logic [RES_W-1:0]  resData1
);
  ctrlStrobe_t      ctrlStrb;
  logic [1:0]       cmdEmpty;
  logic [1:0]       resFull;
  logic [CMD_W-1:0] curCmd;

  seq_control u_ctrl (
    .clk(clk), .rstN(rstN), .ssStart(ssStart), .contEnable(contEnable),
    .doneClr(doneClr), .adcDone(adcDone), .cmdEmpty(cmdEmpty),
    .resFull(resFull), .curEoq(curCmd[EOQ_BIT]), .curRq(curCmd[RQ_BIT]),
    .strb(ctrlStrb), .adcStart(adcStart), .ssBusy(ssBusy), .scanDone(scanDone)
  );

  seq_datapath #(
    .CMD_DEPTH(CMD_DEPTH), .RES_DEPTH(RES_DEPTH), .LOW_MARK(LOW_MARK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmdPush(cmdPush), .cmdWord(cmdWord),
    .contEnable(contEnable), .strb(ctrlStrb), .adcData(adcData),
    .resPop(resPop), .cmdFull(cmdFull), .cmdEmpty(cmdEmpty),
    .refillReq(refillReq), .curCmd(curCmd), .resFull(resFull),
    .resValid(resValid), .resHead0(resData0), .resHead1(resData1)
  );

  assign adcChan   = curCmd[CHAN_W-1:0];
  assign adcSample = curCmd[SMP_HI:SMP_LO];
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       adcStart,
  input logic       ssBusy,
  input logic       contEnable,
  input logic       scanDone,
  input logic       doneClr,
  input logic       eoqDone,
  input logic [1:0] resValid,
  input logic [1:0] resPop
);
  p_start_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  p_idle_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ssBusy) && !$past(contEnable)) |-> !adcStart);

  p_done_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    eoqDone |=> scanDone);

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && !doneClr) |=> scanDone);

  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !eoqDone) |=> !scanDone);

  p_res_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resValid[0] && !resPop[0]) |=> resValid[0]);
endmodule

bind adc_cmd_sequencer seq_checker u_chk (
  .clk(clk), .rstN(rstN), .adcStart(adcStart), .ssBusy(ssBusy),
  .contEnable(contEnable), .scanDone(scanDone), .doneClr(doneClr),
  .eoqDone(ctrlStrb.eoqDone), .resValid(resValid), .resPop(resPop)
);

// File: tb/tb_adc_cmd_sequencer.sv
module tb_adc_cmd_sequencer;
  localparam int CMD_DEPTH = 4;
  localparam int RES_DEPTH = 4;
  localparam int LOW_MARK  = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cmdPush = '0;
  logic [31:0] cmdWord = '0;
  logic        contEnable = 1'b0;
  logic        ssStart = 1'b0;
  logic        doneClr = 1'b0;
  logic [1:0]  cmdFull;
  logic [1:0]  refillReq;
  logic        ssBusy;
  logic        scanDone;
  logic        adcStart;
  logic [7:0]  adcChan;
  logic [1:0]  adcSample;
  logic        adcDone = 1'b0;
  logic [11:0] adcData = '0;
  logic [1:0]  resPop = '0;
  logic [1:0]  resValid;
  logic [15:0] resData0;
  logic [15:0] resData1;

  always #10 clk = ~clk;

  adc_cmd_sequencer #(
    .CMD_DEPTH(CMD_DEPTH), .RES_DEPTH(RES_DEPTH), .LOW_MARK(LOW_MARK)
  ) dut (
    .clk(clk), .rstN(rstN), .cmdPush(cmdPush), .cmdWord(cmdWord),
    .contEnable(contEnable), .ssStart(ssStart), .doneClr(doneClr),
    .cmdFull(cmdFull), .refillReq(refillReq), .ssBusy(ssBusy),
    .scanDone(scanDone), .adcStart(adcStart), .adcChan(adcChan),
    .adcSample(adcSample), .adcDone(adcDone), .adcData(adcData),
    .resPop(resPop), .resValid(resValid), .resData0(resData0),
    .resData1(resData1)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [31:0] q0[$];
  logic [31:0] q1[$];
  logic [15:0] r0[$];
  logic [15:0] r1[$];
  int          ph = 0;
  logic [31:0] mCur = '0;
  int          mSrc = 0;
  logic [15:0] mRes = '0;
  bit          mSs = 0;
  bit          mDone = 0;

  always @(posedge clk) begin
    int          sel;
    int          wr;
    bit          eoqEv;
    bit          pop0;
    bit          pop1;
    logic [31:0] h1;
    eoqEv = 0; pop0 = 0; pop1 = 0; wr = -1; h1 = '0;
    if (!rstN) begin
      q0.delete(); q1.delete(); r0.delete(); r1.delete();
      ph = 0; mCur = '0; mSs = 0; mDone = 0;
    end else begin
      case (ph)
        0: begin
          if (mSs && q0.size() > 0) begin
            mCur = q0[0]; pop0 = 1; mSrc = 0; ph = 1;
          end else if (contEnable && q1.size() > 0) begin
            mCur = q1[0]; h1 = q1[0]; pop1 = 1; mSrc = 1; ph = 1;
          end
        end
        1: ph = 2;
        2: if (adcDone) begin mRes = {4'b0, adcData}; ph = 3; end
        default: begin
          sel = int'(mCur[29]);
          if ((sel == 1 ? r1.size() : r0.size()) < RES_DEPTH) begin
            wr = sel;
            eoqEv = (mSrc == 0) && mCur[31];
            ph = 0;
          end
        end
      endcase
      if (resPop[0] && r0.size() > 0) void'(r0.pop_front());
      if (resPop[1] && r1.size() > 0) void'(r1.pop_front());
      if (wr == 0) r0.push_back(mRes);
      if (wr == 1) r1.push_back(mRes);
      if (pop0) void'(q0.pop_front());
      if (cmdPush[0] && q0.size() < CMD_DEPTH) q0.push_back(cmdWord);
      if (pop1) begin
        void'(q1.pop_front());
        q1.push_back(h1);
      end else if (cmdPush[1] && !contEnable && q1.size() < CMD_DEPTH) begin
        q1.push_back(cmdWord);
      end
      if (eoqEv) mSs = 0;
      if (ssStart) mSs = 1;
      if (doneClr) mDone = 0;
      if (eoqEv) mDone = 1;
    end
  end

  // per-cycle compare and converter responder
  int          pend = 0;
  int          lat = 2;
  int          convSeq = 0;
  logic [7:0]  chanSeen = '0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(adcStart == (ph == 1), "R3 R8 R11 R13 adcStart", 32'(adcStart), 32'(ph == 1));
      if (ph == 1) begin
        chk(adcChan == mCur[7:0], "R2 R3 adcChan", 32'(adcChan), 32'(mCur[7:0]));
        chk(adcSample == mCur[28:27], "R2 adcSample", 32'(adcSample), 32'(mCur[28:27]));
      end
      chk(resValid[0] == (r0.size() > 0), "R9 R11 resValid0", 32'(resValid[0]), 32'(r0.size() > 0));
      chk(resValid[1] == (r1.size() > 0), "R9 R11 resValid1", 32'(resValid[1]), 32'(r1.size() > 0));
      if (r0.size() > 0) chk(resData0 == r0[0], "R9 R10 resData0", 32'(resData0), 32'(r0[0]));
      if (r1.size() > 0) chk(resData1 == r1[0], "R9 R10 resData1", 32'(resData1), 32'(r1[0]));
      chk(cmdFull[0] == (q0.size() == CMD_DEPTH), "R12 cmdFull0", 32'(cmdFull[0]), 32'(q0.size() == CMD_DEPTH));
      chk(cmdFull[1] == (q1.size() == CMD_DEPTH), "R7 R12 cmdFull1", 32'(cmdFull[1]), 32'(q1.size() == CMD_DEPTH));
      chk(refillReq[0] == (q0.size() <= LOW_MARK), "R12 refillReq0", 32'(refillReq[0]), 32'(q0.size() <= LOW_MARK));
      chk(refillReq[1] == (q1.size() <= LOW_MARK), "R7 R12 refillReq1", 32'(refillReq[1]), 32'(q1.size() <= LOW_MARK));
      chk(ssBusy == mSs, "R4 R5 ssBusy", 32'(ssBusy), 32'(mSs));
      chk(scanDone == mDone, "R5 R6 scanDone", 32'(scanDone), 32'(mDone));
    end
    adcDone = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        adcDone = 1'b1;
        adcData = 12'(int'(chanSeen) * 53 + convSeq * 7);
        convSeq++;
      end
    end
    if (rstN && adcStart) begin
      pend = lat;
      chanSeen = adcChan;
    end
  end

  function automatic logic [31:0] mk(input bit eoq, input logic [1:0] rq,
                                     input logic [1:0] smp, input logic [7:0] chan,
                                     input logic [18:0] resv);
    return {eoq, rq, smp, resv, chan};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushCmd(input int q, input logic [31:0] w);
    cmdWord = w;
    cmdPush = (q == 0) ? 2'b01 : 2'b10;
    @(negedge clk);
    cmdPush = 2'b00;
  endtask

  task automatic pulseStart();
    ssStart = 1'b1;
    @(negedge clk);
    ssStart = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R13 watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk(refillReq == 2'b11, "R1 refillReq", 32'(refillReq), 32'h3);
    chk(cmdFull == 2'b00, "R1 cmdFull", 32'(cmdFull), 32'h0);
    chk(resValid == 2'b00, "R1 resValid", 32'(resValid), 32'h0);
    chk({adcStart, ssBusy, scanDone} == 3'b000, "R1 flags", 32'({adcStart, ssBusy, scanDone}), 32'h0);

    // single scan: loaded but not started
    pushCmd(0, mk(0, 2'd0, 2'd3, 8'd5, 19'h0));
    pushCmd(0, mk(0, 2'd2, 2'd1, 8'd9, 19'h5A5A5));
    pushCmd(0, mk(1, 2'd0, 2'd2, 8'd2, 19'h0));
    tick(6);
    chk(adcStart == 1'b0, "R4 no start before enable", 32'(adcStart), 32'h0);
    pulseStart();
    tick(30);
    chk(scanDone == 1'b1, "R5 done after end-of-queue", 32'(scanDone), 32'h1);
    chk(ssBusy == 1'b0, "R5 enable cleared", 32'(ssBusy), 32'h0);
    chk(resValid[0] == 1'b1, "R9 results in fifo0", 32'(resValid[0]), 32'h1);
    resPop = 2'b01;
    tick(3);
    resPop = 2'b00;
    tick(1);
    chk(resValid[0] == 1'b0, "R9 fifo0 drained", 32'(resValid[0]), 32'h0);

    // R6 clear, then clear held through a completion
    doneClr = 1'b1;
    tick(1);
    doneClr = 1'b0;
    tick(1);
    chk(scanDone == 1'b0, "R6 cleared", 32'(scanDone), 32'h0);
    pushCmd(0, mk(0, 2'd0, 2'd3, 8'd17, 19'h0));
    pushCmd(0, mk(1, 2'd0, 2'd3, 8'd18, 19'h0));
    doneClr = 1'b1;
    pulseStart();
    tick(30);
    doneClr = 1'b0;
    tick(1);
    chk(scanDone == 1'b0, "R6 clear after coincident set", 32'(scanDone), 32'h0);
    resPop = 2'b01;
    tick(3);
    resPop = 2'b00;

    // continuous queue: fill, overfill, enable, back-pressure
    pushCmd(1, mk(0, 2'd1, 2'd3, 8'd40, 19'h0));
    pushCmd(1, mk(0, 2'd1, 2'd0, 8'd41, 19'h0));
    pushCmd(1, mk(0, 2'd0, 2'd3, 8'd42, 19'h0));
    pushCmd(1, mk(1, 2'd3, 2'd1, 8'd43, 19'h0));
    chk(cmdFull[1] == 1'b1, "R12 queue1 full", 32'(cmdFull[1]), 32'h1);
    pushCmd(1, mk(0, 2'd1, 2'd3, 8'd99, 19'h0));
    contEnable = 1'b1;
    pushCmd(1, mk(0, 2'd1, 2'd3, 8'd98, 19'h0));
    tick(60);
    chk(cmdFull[1] == 1'b1, "R7 recirculation keeps queue1 full", 32'(cmdFull[1]), 32'h1);
    pushCmd(0, mk(1, 2'd0, 2'd2, 8'd7, 19'h0));
    pulseStart();
    resPop = 2'b11;
    tick(60);
    resPop = 2'b00;
    contEnable = 1'b0;
    tick(20);
    resPop = 2'b11;
    tick(10);
    resPop = 2'b00;

    // randomized traffic
    for (int i = 0; i < 4000; i++) begin
      cmdWord = mk(1'($urandom_range(0, 3) == 0), 2'($urandom), 2'($urandom),
                   8'($urandom), 19'($urandom));
      cmdPush = 2'($urandom_range(0, 3) == 0 ? $urandom : 0);
      ssStart = ($urandom_range(0, 19) == 0);
      doneClr = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) contEnable = ~contEnable;
      resPop = 2'($urandom);
      lat = $urandom_range(1, 3);
      tick(1);
    end
    cmdPush = '0; ssStart = 0; doneClr = 0; contEnable = 0; resPop = 2'b11;
    tick(40);
    summary();
  end
endmodule